// File: doc/BRIEF.md
# Ring Signal Frequency Qualifier

This block decides whether an incoming ring signal has an acceptable frequency. Upstream line sensing delivers a single-cycle pulse each time the ring voltage crosses its detection threshold, which normally happens twice per ring-tone period. A free-running 2 ms strobe paces two timers inside the block. The first is an interval timer. Each crossing reloads it with a programmable start value, and it then counts down toward zero. The second is a silence timer that measures the time since the most recent crossing.

When a crossing arrives during an ongoing ring, the block compares the residual interval count with a programmable maximum. A residual above the maximum means the crossings are too close together. The difference between the start value and the maximum is therefore the shortest accepted spacing, in 2 ms steps. One passing comparison marks the ring valid. One failing comparison marks it invalid, and it stays invalid for the rest of that ring. When no crossing has arrived for the coded silence time, the block emits a one-cycle end-of-ring pulse and returns to idle.

The 8-bit control input packs the silence code and the maximum count. The block takes both fields and the start value when a ring begins, so host writes made during a ring do not disturb the qualification in progress.

Top module: `ring_freq_qual`

## Requirements
- R1: After reset, ring_valid_o, ring_invalid_o and ring_over_o are all low and the block is idle.
- R2: ctrl_i bits 7:4 carry the silence code and bits 3:0 carry the maximum count; the silence limit is 40 ticks for code 0 and code x 64 ticks for codes 1 to 15.
- R3: Each crossing reloads the interval timer with start_val_i. Each later tick lowers the timer by one, and the timer holds at zero instead of wrapping.
- R4: A crossing during a ring whose residual interval count is greater than the maximum count raises ring_invalid_o from the next cycle, with ring_valid_o low.
- R5: A crossing during a ring that is not invalid, whose residual count is at most the maximum count, makes ring_valid_o high from the next cycle.
- R6: A crossing while idle only starts a ring: it makes no comparison, and both ring_valid_o and ring_invalid_o stay low.
- R7: On the tick that completes the silence limit after the last crossing, ring_over_o pulses high for exactly one cycle starting the next cycle. At the same edge ring_valid_o and ring_invalid_o drop and the block returns to idle.
- R8: ring_invalid_o stays high, and ring_valid_o stays low, until ring_over_o ends the ring, whatever crossings arrive in between.
- R9: ctrl_i and start_val_i are captured by the crossing that starts a ring; changes to them before that ring ends have no effect.
- R10: A crossing in the same cycle as a tick takes precedence: the timer reloads, the silence count restarts from zero, and that tick does not count toward either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crossing_i | input | 1 | Single-cycle threshold-crossing pulse |
| tick_i | input | 1 | Single-cycle 2 ms timing strobe |
| start_val_i | input | 6 | Interval timer reload value, in ticks |
| ctrl_i | input | 8 | Bits 7:4 silence code, bits 3:0 maximum count |
| ring_valid_o | output | 1 | Ring frequency qualified |
| ring_invalid_o | output | 1 | Ring rejected as too fast |
| ring_over_o | output | 1 | One-cycle end-of-ring pulse |

## Verification
A wrong residual in the interval timer shows up at the next crossing, one cycle later, as ring_valid_o and ring_invalid_o taking the wrong values. A missed reload or a wrap through zero therefore shows within a single event spacing. A wrong silence count or a wrong decode of the code field moves the ring_over_o pulse by whole ticks. The bench catches this by checking the pulse on the exact tick, with one tick of tolerance on neither side. Parameters latched at the wrong moment show up in the same two places, but only once the host changes ctrl_i during a ring. The bench therefore changes those inputs on every cycle of a ring.

// File: rtl/ring_qual_pkg.sv
package ring_qual_pkg;

  typedef enum logic [1:0] {
    RQ_IDLE    = 2'd0,
    RQ_ARMED   = 2'd1,
    RQ_VALID   = 2'd2,
    RQ_INVALID = 2'd3
  } rq_state_e;

  // Silence limit in ticks for a given code: the zero code has its own length,
  // every other code is a multiple of the step length.
  function automatic int silence_limit(input int code, input int step_ticks,
                                       input int code0_ticks);
    if (code == 0) return code0_ticks;
    return code * step_ticks;
  endfunction

  // Width able to hold the largest silence limit.
  function automatic int silence_width(input int code_w, input int step_ticks,
                                       input int code0_ticks);
    int top;
    top = ((1 << code_w) - 1) * step_ticks;
    if (code0_ticks > top) top = code0_ticks;
    return $clog2(top + 1);
  endfunction

endpackage

// File: rtl/rq_param_hold.sv
module rq_param_hold #(
  parameter int START_W = 6,
  parameter int MAX_W   = 4,
  parameter int CODE_W  = 4,
  parameter logic [CODE_W+MAX_W-1:0] CTRL_RST = 8'h16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idle_i,
  input  logic                      capture_i,
  input  logic [START_W-1:0]        start_live_i,
  input  logic [CODE_W+MAX_W-1:0]   ctrl_live_i,
  output logic [START_W-1:0]        start_eff_o,
  output logic [MAX_W-1:0]          max_eff_o,
  output logic [CODE_W-1:0]         code_eff_o
);
  localparam int CTRL_W = CODE_W + MAX_W;

  logic [START_W-1:0] start_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [CTRL_W-1:0]  ctrl_eff;

  // While idle the live fields are in force; a ring runs on the held copy.
  assign ctrl_eff    = idle_i ? ctrl_live_i  : ctrl_q;
  assign start_eff_o = idle_i ? start_live_i : start_q;
  assign code_eff_o  = ctrl_eff[CTRL_W-1 -: CODE_W];
  assign max_eff_o   = ctrl_eff[MAX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ctrl_q  <= CTRL_RST;
    end else if (capture_i && idle_i) begin
      start_q <= start_live_i;
      ctrl_q  <= ctrl_live_i;
    end
  end
endmodule

// File: rtl/rq_interval_timer.sv
module rq_interval_timer #(
  parameter int START_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               tick_i,
  input  logic [START_W-1:0] load_val_i,
  output logic [START_W-1:0] count_o,
  output logic               at_zero_o
);
  logic [START_W-1:0] cnt_q;

  assign count_o   = cnt_q;
  assign at_zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && !at_zero_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rq_silence_timer.sv
module rq_silence_timer #(
  parameter int SIL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [SIL_W-1:0] limit_i,
  output logic             expire_o
);
  logic [SIL_W-1:0] sil_q;
  logic [SIL_W:0]   sil_next;

  assign sil_next = {1'b0, sil_q} + 1'b1;
  assign expire_o = active_i && tick_i && !restart_i &&
                    (sil_next == {1'b0, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sil_q <= '0;
    end else if (restart_i || !active_i || expire_o) begin
      sil_q <= '0;
    end else if (tick_i) begin
      sil_q <= sil_next[SIL_W-1:0];
    end
  end
endmodule

// File: rtl/rq_state_ctrl.sv
module rq_state_ctrl
  import ring_qual_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      crossing_i,
  input  logic      too_fast_i,
  input  logic      expire_i,
  output rq_state_e state_o,
  output logic      over_o
);
  rq_state_e state_q, state_d;
  logic      over_q;

  assign state_o = state_q;
  assign over_o  = over_q;

  always_comb begin
    state_d = state_q;
    if (crossing_i) begin
      unique case (state_q)
        RQ_IDLE:    state_d = RQ_ARMED;
        RQ_ARMED:   state_d = too_fast_i ? RQ_INVALID : RQ_VALID;
        RQ_VALID:   state_d = too_fast_i ? RQ_INVALID : RQ_VALID;
        RQ_INVALID: state_d = RQ_INVALID;
        default:    state_d = RQ_IDLE;
      endcase
    end else if (expire_i) begin
      state_d = RQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      over_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      over_q  <= expire_i && !crossing_i;
    end
  end
endmodule

// File: rtl/ring_freq_qual.sv
module ring_freq_qual
  import ring_qual_pkg::*;
#(
  parameter int START_W     = 6,
  parameter int MAX_W       = 4,
  parameter int CODE_W      = 4,
  parameter int STEP_TICKS  = 64,
  parameter int CODE0_TICKS = 40,
  parameter logic [CODE_W+MAX_W-1:0] CTRL_RST = 8'h16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     crossing_i,
  input  logic                     tick_i,
  input  logic [START_W-1:0]       start_val_i,
  input  logic [CODE_W+MAX_W-1:0]  ctrl_i,
  output logic                     ring_valid_o,
  output logic                     ring_invalid_o,
  output logic                     ring_over_o
);
  localparam int SIL_W = silence_width(CODE_W, STEP_TICKS, CODE0_TICKS);

  // Named internal events, visible to the bound checker.
  rq_state_e          state;
  logic               state_idle;
  logic               ring_active;
  logic [START_W-1:0] eff_start;
  logic [MAX_W-1:0]   eff_max;
  logic [CODE_W-1:0]  eff_code;
  logic [SIL_W-1:0]   sil_limit;
  logic [START_W-1:0] ivl_cnt;
  logic               ivl_zero;
  logic               cmp_too_fast;
  logic               sil_expire;

  assign state_idle   = (state == RQ_IDLE);
  assign ring_active  = !state_idle;
  assign sil_limit    = SIL_W'(silence_limit(int'(eff_code), STEP_TICKS, CODE0_TICKS));
  assign cmp_too_fast = (ivl_cnt > START_W'(eff_max));

  rq_param_hold #(
    .START_W (START_W),
    .MAX_W   (MAX_W),
    .CODE_W  (CODE_W),
    .CTRL_RST(CTRL_RST)
  ) u_param (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_i      (state_idle),
    .capture_i   (crossing_i),
    .start_live_i(start_val_i),
    .ctrl_live_i (ctrl_i),
    .start_eff_o (eff_start),
    .max_eff_o   (eff_max),
    .code_eff_o  (eff_code)
  );

  rq_interval_timer #(.START_W(START_W)) u_ivl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (crossing_i),
    .tick_i    (tick_i),
    .load_val_i(eff_start),
    .count_o   (ivl_cnt),
    .at_zero_o (ivl_zero)
  );

  rq_silence_timer #(.SIL_W(SIL_W)) u_sil (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (ring_active),
    .restart_i(crossing_i),
    .tick_i   (tick_i),
    .limit_i  (sil_limit),
    .expire_o (sil_expire)
  );

  rq_state_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .crossing_i(crossing_i),
    .too_fast_i(cmp_too_fast),
    .expire_i  (sil_expire),
    .state_o   (state),
    .over_o    (ring_over_o)
  );

  assign ring_valid_o   = (state == RQ_VALID);
  assign ring_invalid_o = (state == RQ_INVALID);
endmodule

// File: rtl/ring_freq_qual_chk.sv
module ring_freq_qual_chk #(
  parameter int START_W = 6,
  parameter int MAX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               crossing_i,
  input logic               tick_i,
  input logic               state_idle,
  input logic [START_W-1:0] ivl_cnt,
  input logic               ivl_zero,
  input logic [START_W-1:0] eff_start,
  input logic [MAX_W-1:0]   eff_max,
  input logic               ring_valid_o,
  input logic               ring_invalid_o,
  input logic               ring_over_o
);
  // R3: reload on a crossing
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crossing_i |=> (ivl_cnt == $past(eff_start)));

  // R3: timer holds at zero
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_zero && tick_i && !crossing_i) |=> (ivl_cnt == '0));

  // R4: residual above maximum rejects the ring
  assert_too_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (crossing_i && !state_idle && (ivl_cnt > START_W'(eff_max)))
      |=> (ring_invalid_o && !ring_valid_o));

  // R5: passing comparison qualifies the ring
  assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crossing_i && !state_idle && !ring_invalid_o && (ivl_cnt <= START_W'(eff_max)))
      |=> ring_valid_o);

  // R6: first crossing makes no decision
  assert_first_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (crossing_i && state_idle) |=> (!ring_valid_o && !ring_invalid_o));

  // R7: end-of-ring pulse is one cycle and lands in idle
  assert_over_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_over_o |=> !ring_over_o);
  assert_over_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_over_o |-> (state_idle && !ring_valid_o && !ring_invalid_o));

  // R8: rejection is sticky until the ring ends
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_invalid_o |=> (ring_invalid_o || ring_over_o));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_valid_o && ring_invalid_o));
endmodule

bind ring_freq_qual ring_freq_qual_chk #(
  .START_W(START_W),
  .MAX_W  (MAX_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .crossing_i    (crossing_i),
  .tick_i        (tick_i),
  .state_idle    (state_idle),
  .ivl_cnt       (ivl_cnt),
  .ivl_zero      (ivl_zero),
  .eff_start     (eff_start),
  .eff_max       (eff_max),
  .ring_valid_o  (ring_valid_o),
  .ring_invalid_o(ring_invalid_o),
  .ring_over_o   (ring_over_o)
);

// File: tb/test_ring_freq_qual.sv
`timescale 1ns/1ps
module test_ring_freq_qual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       crossing = 1'b0;
  logic       tick = 1'b0;
  logic [5:0] start_val = 6'd0;
  logic [7:0] ctrl = 8'h16;
  logic       valid, invalid, over;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // bench model: 0 idle, 1 armed, 2 valid, 3 invalid
  int m_st = 0;
  int m_since = 0;
  int m_start = 0;
  int m_max = 0;
  int m_code = 0;
  bit m_over = 1'b0;

  always #2 clk = ~clk;

  ring_freq_qual i_ring_freq_qual (
    .clk(clk), .rst_n(rst_n), .crossing_i(crossing), .tick_i(tick),
    .start_val_i(start_val), .ctrl_i(ctrl),
    .ring_valid_o(valid), .ring_invalid_o(invalid), .ring_over_o(over)
  );

  function automatic int exp_limit(input int code);
    // 128 ms per code step is 64 ticks; code zero is 80 ms
    return (code == 0) ? 40 : (code << 6);
  endfunction

  function automatic int residual(input int st, input int since);
    return (since >= st) ? 0 : st - since;
  endfunction

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit ev, input bit tk);
    m_over = 1'b0;
    if (ev) begin
      if (m_st == 0) begin
        m_start = int'(start_val);
        m_max   = int'(ctrl[3:0]);
        m_code  = int'(ctrl[7:4]);
        m_st    = 1;
      end else if (m_st != 3) begin
        m_st = (residual(m_start, m_since) > m_max) ? 3 : 2;
      end
      m_since = 0;
    end else if (tk && m_st != 0) begin
      m_since++;
      if (m_since >= exp_limit(m_code)) begin
        m_st = 0;
        m_over = 1'b1;
        m_since = 0;
      end
    end
  endtask

  // one clock: drive after a falling edge, compare 1 ns after the rising edge
  task automatic step(input bit ev, input bit tk);
    crossing = ev;
    tick = tk;
    model(ev, tk);
    @(posedge clk);
    #1;
    check(int'(valid),   (m_st == 2) ? 1 : 0, "valid");
    check(int'(invalid), (m_st == 3) ? 1 : 0, "invalid");
    check(int'(over),    int'(m_over),        "over");
    @(negedge clk);
    crossing = 1'b0;
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    tag = "R1";
    check(int'(valid), 0, "reset valid");
    check(int'(invalid), 0, "reset invalid");
    check(int'(over), 0, "reset over");
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b0);

    // code 1 (64 ticks), maximum 6, start 20: spacing of 14 ticks passes
    tag = "R6"; ctrl = 8'h16; start_val = 6'd20;
    step(1'b1, 1'b0);
    check(int'(valid), 0, "first crossing no valid");
    check(int'(invalid), 0, "first crossing no invalid");
    tag = "R9"; ctrl = 8'h0F; start_val = 6'd63;   // mid-ring change ignored
    tag = "R5"; ticks(14); step(1'b1, 1'b0);
    check(int'(valid), 1, "spacing 14 ticks residual 6");
    tag = "R4"; ticks(13); step(1'b1, 1'b0);
    check(int'(invalid), 1, "spacing 13 ticks residual 7");
    check(int'(valid), 0, "valid low after reject");
    tag = "R8"; ticks(20); step(1'b1, 1'b0);
    check(int'(invalid), 1, "reject sticky after good spacing");
    tag = "R9"; ticks(63);
    check(int'(over), 0, "no end before held code 1 limit");
    step(1'b0, 1'b1);
    check(int'(over), 1, "end after 64 ticks from held code");
    tag = "R7"; step(1'b0, 1'b0);
    check(int'(over), 0, "end pulse one cycle");
    check(int'(invalid), 0, "cleared at end");

    // field positions: code 0 (40 ticks) in 7:4, maximum 3 in 3:0
    tag = "R2"; ctrl = 8'h03; start_val = 6'd10;
    step(1'b1, 1'b0); ticks(7); step(1'b1, 1'b0);
    check(int'(valid), 1, "maximum read from low nibble");
    ticks(39);
    check(int'(over), 0, "no end before 40 ticks");
    step(1'b0, 1'b1);
    check(int'(over), 1, "code zero ends at 40 ticks");

    // saturation: start 5, maximum 0, long wait passes
    tag = "R3"; ctrl = 8'h10; start_val = 6'd5;
    step(1'b1, 1'b0); ticks(20); step(1'b1, 1'b0);
    check(int'(valid), 1, "timer held at zero");
    ticks(64);
    check(int'(valid), 0, "ring ended");

    // crossing with tick in the same cycle
    tag = "R10"; ctrl = 8'h12; start_val = 6'd4;
    step(1'b1, 1'b0); ticks(2); step(1'b1, 1'b1);
    check(int'(valid), 1, "coincident crossing compares residual 2");
    ticks(2); step(1'b1, 1'b0);
    check(int'(valid), 1, "coincident tick not counted in reload");
    ticks(63);
    check(int'(over), 0, "silence restarted by crossing");
    step(1'b0, 1'b1);
    check(int'(over), 1, "end 64 ticks after last crossing");
    step(1'b0, 1'b0);

    // constrained random rings, control inputs churned during each ring
    tag = "R4 R5 R7 R8 R9";
    for (int r = 0; r < 40; r++) begin
      int nev;
      int cyc;
      cyc = 0;
      ctrl = {((r % 13) == 5) ? 4'hF : 4'($urandom % 4), 4'($urandom % 16)};
      start_val = 6'(1 + $urandom % 63);
      nev = 2 + $urandom % 7;
      for (int e = 0; e < nev; e++) begin
        int gap;
        gap = $urandom % (3 * (int'(start_val) + 4));
        for (int g = 0; g < gap; g++) begin
          step(1'b0, (cyc % 3) == 0);
          cyc++;
          ctrl = 8'($urandom);
          start_val = 6'($urandom);
        end
        step(1'b1, (cyc % 3) == 0);
        cyc++;
      end
      for (int w = 0; w < 4000 && m_st != 0; w++) begin
        step(1'b0, (cyc % 3) == 0);
        cyc++;
      end
      step(1'b0, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule